// File: doc/BRIEF.md
# Bus-Master Descriptor Fetch Sequencer

This block is the read engine that a network controller uses when it is the master of a simplified PCI-style parallel bus. It fetches two kinds of object from host memory. The first is the setup block, which is always read as one linear burst of a fixed number of dwords. The second is a ring descriptor, which is read either as one burst or as a series of separate one-dword transactions, depending on the descriptor layout mode. The block drives the address phase, the command, the byte enables and the framing signals. It captures each returned dword into a small output buffer and pulses `done` when the whole fetch has finished.

While the block owns the bus, it checks even parity on every accepted data phase. A mismatch sets a sticky system-interrupt status bit, and the interrupt line follows that bit through an enable. A parity error never changes the transfer: the data is kept as if it were good, and the sequence runs on unchanged.

A fetch starts with a request handshake on `req_valid`/`req_ready`, carrying a base address and a fetch kind.

Top module: `desc_fetch_seq`

## Requirements
- R1: A setup fetch (`req_setup`=1) is exactly one transaction. Its address phase carries command 4'b1100 (read-multiple) on `bus_cbe_n`, and it has exactly SETUP_DW accepted data phases, with `bus_frame` held high from the address phase to the last accepted data phase.
- R2: On every address phase, `bus_ad_out` equals the transfer address with bits [1:0] forced to 0, which marks linear burst order. The first transaction uses `req_base`, and each further single transaction of a descriptor uses the previous address plus 4.
- R3: During every data phase (`bus_frame` and `bus_irdy` high), `bus_cbe_n` is 4'b0000, so all four byte lanes are enabled.
- R4: In a descriptor fetch with `layout_mode` equal to 0 or 2, the block issues DESC_DW separate transactions, each with command 4'b0110 and one data phase. After each one the bus is idle before the next address phase. For any other `layout_mode`, the descriptor is one transaction with command 4'b1100 and DESC_DW data phases.
- R5: The dword from the i-th accepted data phase appears at `rd_data[32*i +: 32]`. In a descriptor fetch, byte b of dword i reads as zero when DESC_KEEP bit 4*i+b is 0. Slots not written by the current fetch read as zero, and `rd_count` equals the number of dwords fetched.
- R6: In the cycle after the last accepted data phase, `bus_frame` is 0 and `bus_irdy` is 1. In the cycle after that, both are 0, `done` is high for that one cycle, and `req_ready` is high. `req_ready` is high only while the block is idle.
- R7: Parity is even over `bus_ad_in`, `bus_cbe_n` and `bus_par`, and it is checked on each accepted data phase. A mismatch sets `sint_stat`, which is visible no later than the cycle in which `done` pulses. The bit stays set until it is cleared.
- R8: A parity error neither aborts nor changes a fetch. The same number of transactions and data phases follows, and the affected dword is stored as received.
- R9: `irq` is high exactly when `sint_stat` and `sint_en` are both 1.
- R10: A one-cycle pulse on `sint_clr` clears `sint_stat`. A parity error in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Fetch request |
| req_ready | output | 1 | Block idle; a request is taken on this cycle |
| req_base | input | 32 | Base byte address of the fetch |
| req_setup | input | 1 | 1 = setup-block fetch, 0 = descriptor fetch |
| layout_mode | input | 8 | Descriptor layout mode |
| done | output | 1 | One-cycle pulse when the fetch has finished |
| rd_count | output | CNT_W | Number of dwords fetched |
| rd_data | output | 32*BUF_DW | Captured dwords, slot i at bits 32*i+31..32*i |
| bus_frame | output | 1 | Transaction framing, active high |
| bus_irdy | output | 1 | Initiator ready, active high |
| bus_ad_oe | output | 1 | Block drives the address/data lines (address phase) |
| bus_ad_out | output | 32 | Address driven in the address phase |
| bus_cbe_n | output | 4 | Command in the address phase, active-low byte enables in data phases |
| bus_trdy | input | 1 | Target ready, active high |
| bus_ad_in | input | 32 | Read data from the target |
| bus_par | input | 1 | Even parity bit for the data phase |
| sint_en | input | 1 | Interrupt enable |
| sint_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| sint_stat | output | 1 | Sticky data-parity status bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: SETUP_DW=7, DESC_DW=4 and DESC_KEEP=16'hBFFF. These values give a seven-beat setup burst and a four-dword descriptor in which byte 2 of dword 3 is dropped. Running a descriptor fetch after a setup fetch exercises buffer slots that the descriptor fetch must clear. The bench target can insert wait states on alternate cycles, so both back-to-back and stretched data phases occur in burst and single modes. It can also corrupt the parity of any chosen data phase, which exercises the status bit, its mask and its clear, and confirms that the traffic is unchanged.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_TAIL,
    ST_GAP
  } dfs_state_e;

  localparam logic [3:0] CMD_RD_SINGLE = 4'b0110;
  localparam logic [3:0] CMD_RD_MULTI  = 4'b1100;
  localparam logic [3:0] BE_ALL_LANES  = 4'b0000;
  localparam logic [3:0] BE_NONE       = 4'b1111;

  // Layout modes whose descriptors must be read one dword at a time
  function automatic logic mode_is_single(input logic [7:0] mode);
    return (mode == 8'd0) || (mode == 8'd2);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] keep);
    return {{8{keep[3]}}, {8{keep[2]}}, {8{keep[1]}}, {8{keep[0]}}};
  endfunction

endpackage

// File: rtl/dfs_ctrl.sv
module dfs_ctrl
  import dfs_pkg::*;
#(
  parameter int SETUP_DW = 7,
  parameter int DESC_DW  = 4,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_base,
  input  logic             req_setup,
  input  logic [7:0]       layout_mode,
  output logic             bus_frame,
  output logic             bus_irdy,
  output logic             bus_ad_oe,
  output logic [31:0]      bus_ad_out,
  output logic [3:0]       bus_cbe_n,
  input  logic             bus_trdy,
  output logic             start,
  output logic             cap_en,
  output logic [CNT_W-1:0] cap_idx,
  output logic             cap_setup,
  output logic             done,
  output logic [CNT_W-1:0] count
);

  dfs_state_e       st_q, st_d;
  logic [31:0]      addr_q, addr_d;
  logic             setup_q, setup_d;
  logic             burst_q, burst_d;
  logic [CNT_W-1:0] xfer_q, xfer_d;
  logic [CNT_W-1:0] txn_q, txn_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             single_sel;

  assign single_sel = !req_setup && mode_is_single(layout_mode);

  // Next-state process
  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    setup_d = setup_q;
    burst_d = burst_q;
    xfer_d  = xfer_q;
    txn_d   = txn_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    start   = 1'b0;
    cap_en  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d    = ST_ADDR;
          addr_d  = req_base & ~32'h3;
          setup_d = req_setup;
          burst_d = !single_sel;
          idx_d   = '0;
          start   = 1'b1;
          if (req_setup) begin
            xfer_d = CNT_W'(SETUP_DW);
            txn_d  = CNT_W'(1);
          end else if (single_sel) begin
            xfer_d = CNT_W'(1);
            txn_d  = CNT_W'(DESC_DW);
          end else begin
            xfer_d = CNT_W'(DESC_DW);
            txn_d  = CNT_W'(1);
          end
        end
      end
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: begin
        if (bus_trdy) begin
          cap_en = 1'b1;
          idx_d  = idx_q + CNT_W'(1);
          addr_d = addr_q + 32'd4;
          xfer_d = xfer_q - CNT_W'(1);
          if (xfer_q == CNT_W'(1)) st_d = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (txn_q == CNT_W'(1)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d   = ST_GAP;
          txn_d  = txn_q - CNT_W'(1);
          xfer_d = CNT_W'(1);
        end
      end
      ST_GAP:  st_d = ST_ADDR;
      default: st_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      setup_q <= 1'b0;
      burst_q <= 1'b0;
      xfer_q  <= '0;
      txn_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      setup_q <= setup_d;
      burst_q <= burst_d;
      xfer_q  <= xfer_d;
      txn_q   <= txn_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign bus_frame  = (st_q == ST_ADDR) || (st_q == ST_DATA);
  assign bus_irdy   = (st_q == ST_DATA) || (st_q == ST_TAIL);
  assign bus_ad_oe  = (st_q == ST_ADDR);
  assign bus_ad_out = (st_q == ST_ADDR) ? addr_q : 32'd0;
  always_comb begin
    if (st_q == ST_ADDR)       bus_cbe_n = burst_q ? CMD_RD_MULTI : CMD_RD_SINGLE;
    else if (bus_irdy)         bus_cbe_n = BE_ALL_LANES;
    else                       bus_cbe_n = BE_NONE;
  end
  assign cap_idx   = idx_q;
  assign cap_setup = setup_q;
  assign done      = done_q;
  assign count     = idx_q;

  // R1: a setup transaction ends only after exactly SETUP_DW beats
  a_r1_setup_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TAIL && setup_q) |-> idx_q == CNT_W'(SETUP_DW));
  // R2: address phase carries linear-order low bits
  a_r2_linear_order: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ad_oe |-> bus_ad_out[1:0] == 2'b00);
  // R3: every data phase enables all lanes
  a_r3_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_frame && bus_irdy) |-> bus_cbe_n == BE_ALL_LANES);
  // R4: a single-mode transaction ends after its one beat
  a_r4_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && bus_trdy && !burst_q) |=> !bus_frame);
  // R6: initiator ready is released one cycle after frame
  a_r6_irdy_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_frame && bus_irdy) |=> (!bus_irdy && !bus_frame));

endmodule

// File: rtl/dfs_capture.sv
module dfs_capture
  import dfs_pkg::*;
#(
  parameter int                   DESC_DW   = 4,
  parameter logic [4*DESC_DW-1:0] DESC_KEEP = 16'hBFFF,
  parameter int                   BUF_DW    = 7,
  parameter int                   CNT_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cap_en,
  input  logic [CNT_W-1:0]    cap_idx,
  input  logic                cap_setup,
  input  logic [31:0]         cap_data,
  output logic [32*BUF_DW-1:0] rd_data
);

  for (genvar g = 0; g < BUF_DW; g++) begin : g_slot
    logic [31:0] slot_q;
    logic [31:0] keep_w;
    logic        wr_en;

    if (g < DESC_DW) begin : g_desc
      assign keep_w = cap_setup ? 32'hFFFF_FFFF : lane_mask(DESC_KEEP[4*g +: 4]);
    end else begin : g_setup_only
      assign keep_w = 32'hFFFF_FFFF;
    end

    assign wr_en = cap_en && (cap_idx == CNT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q <= '0;
      else if (start) slot_q <= '0;
      else if (wr_en) slot_q <= cap_data & keep_w;
    end

    assign rd_data[32*g +: 32] = slot_q;
  end

  // R5: a new fetch starts from an empty buffer
  a_r5_buffer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> rd_data == '0);

endmodule

// File: rtl/dfs_parity.sv
module dfs_parity (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chk_en,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  input  logic        par_in,
  input  logic        sint_en,
  input  logic        sint_clr,
  output logic        sint_stat,
  output logic        irq
);

  logic        chk_q;
  logic [31:0] ad_q;
  logic [3:0]  cbe_q;
  logic        par_q;
  logic        perr;
  logic        stat_q, stat_d;

  // Sample the accepted data phase, check it one clock later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q <= 1'b0;
      ad_q  <= '0;
      cbe_q <= '0;
      par_q <= 1'b0;
    end else begin
      chk_q <= chk_en;
      if (chk_en) begin
        ad_q  <= ad_in;
        cbe_q <= cbe_n;
        par_q <= par_in;
      end
    end
  end

  assign perr = chk_q && (^{ad_q, cbe_q, par_q});

  always_comb begin
    stat_d = stat_q;
    if (perr)          stat_d = 1'b1;
    else if (sint_clr) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign sint_stat = stat_q;
  assign irq       = stat_q && sint_en;

  // R7: a detected error is recorded
  a_r7_error_sets: assert property (@(posedge clk) disable iff (!rst_n)
    perr |=> sint_stat);
  // R7: status is sticky without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sint_stat && !sint_clr) |=> sint_stat);
  // R10: a clear without a simultaneous error empties the bit
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sint_clr && !perr) |=> !sint_stat);

endmodule

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq
  import dfs_pkg::*;
#(
  parameter int                   SETUP_DW  = 7,
  parameter int                   DESC_DW   = 4,
  parameter logic [4*DESC_DW-1:0] DESC_KEEP = 16'hBFFF,
  localparam int                  BUF_DW    = (SETUP_DW > DESC_DW) ? SETUP_DW : DESC_DW,
  localparam int                  CNT_W     = $clog2(BUF_DW + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [31:0]          req_base,
  input  logic                 req_setup,
  input  logic [7:0]           layout_mode,
  output logic                 done,
  output logic [CNT_W-1:0]     rd_count,
  output logic [32*BUF_DW-1:0] rd_data,
  output logic                 bus_frame,
  output logic                 bus_irdy,
  output logic                 bus_ad_oe,
  output logic [31:0]          bus_ad_out,
  output logic [3:0]           bus_cbe_n,
  input  logic                 bus_trdy,
  input  logic [31:0]          bus_ad_in,
  input  logic                 bus_par,
  input  logic                 sint_en,
  input  logic                 sint_clr,
  output logic                 sint_stat,
  output logic                 irq
);

  logic             rst_meta_q, rst_sync_q;
  logic             start, cap_en, cap_setup;
  logic [CNT_W-1:0] cap_idx;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dfs_ctrl #(.SETUP_DW(SETUP_DW), .DESC_DW(DESC_DW), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_q),
    .req_valid(req_valid), .req_ready(req_ready), .req_base(req_base),
    .req_setup(req_setup), .layout_mode(layout_mode),
    .bus_frame(bus_frame), .bus_irdy(bus_irdy), .bus_ad_oe(bus_ad_oe),
    .bus_ad_out(bus_ad_out), .bus_cbe_n(bus_cbe_n), .bus_trdy(bus_trdy),
    .start(start), .cap_en(cap_en), .cap_idx(cap_idx), .cap_setup(cap_setup),
    .done(done), .count(rd_count)
  );

  dfs_capture #(.DESC_DW(DESC_DW), .DESC_KEEP(DESC_KEEP), .BUF_DW(BUF_DW),
                .CNT_W(CNT_W)) u_capture (
    .clk(clk), .rst_n(rst_sync_q), .start(start), .cap_en(cap_en),
    .cap_idx(cap_idx), .cap_setup(cap_setup), .cap_data(bus_ad_in),
    .rd_data(rd_data)
  );

  dfs_parity u_parity (
    .clk(clk), .rst_n(rst_sync_q), .chk_en(cap_en), .ad_in(bus_ad_in),
    .cbe_n(bus_cbe_n), .par_in(bus_par), .sint_en(sint_en),
    .sint_clr(sint_clr), .sint_stat(sint_stat), .irq(irq)
  );

endmodule

// File: tb/desc_fetch_seq_bench.sv
module desc_fetch_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP_DW   = 7;
  localparam int DESC_DW    = 4;
  localparam logic [15:0] DESC_KEEP = 16'hBFFF;
  localparam int BUF_DW     = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_setup;
  logic [31:0] req_base;
  logic [7:0]  layout_mode;
  logic done;
  logic [2:0] rd_count;
  logic [32*BUF_DW-1:0] rd_data;
  logic bus_frame, bus_irdy, bus_ad_oe;
  logic [31:0] bus_ad_out;
  logic [3:0]  bus_cbe_n;
  logic bus_trdy, bus_par;
  logic [31:0] bus_ad_in;
  logic sint_en, sint_clr, sint_stat, irq;

  int checks = 0;
  int failures = 0;

  // Target model state
  int txn_cnt, phase_cnt, bad_idx, be_err, gap_cnt;
  bit wait_mode, tog, prev_tail;
  logic [31:0] cur_addr;
  logic [31:0] txn_addr [0:15];
  logic [3:0]  txn_cmd  [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_fetch_seq u_desc_fetch_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_setup(req_setup), .layout_mode(layout_mode),
    .done(done), .rd_count(rd_count), .rd_data(rd_data),
    .bus_frame(bus_frame), .bus_irdy(bus_irdy), .bus_ad_oe(bus_ad_oe),
    .bus_ad_out(bus_ad_out), .bus_cbe_n(bus_cbe_n), .bus_trdy(bus_trdy),
    .bus_ad_in(bus_ad_in), .bus_par(bus_par), .sint_en(sint_en),
    .sint_clr(sint_clr), .sint_stat(sint_stat), .irq(irq)
  );

  function automatic logic [31:0] mem(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] desc_mask(input int i);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = DESC_KEEP[4*i+b] ? 8'hFF : 8'h00;
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Bus target responder, acting on falling edges
  task automatic target_serve();
    forever begin
      @(negedge clk);
      if (prev_tail && !bus_frame && !bus_irdy) gap_cnt++;
      prev_tail = !bus_frame && bus_irdy;
      if (bus_frame && !bus_irdy) begin
        if (txn_cnt < 16) begin
          txn_addr[txn_cnt] = bus_ad_out;
          txn_cmd[txn_cnt]  = bus_cbe_n;
        end
        txn_cnt++;
        cur_addr = bus_ad_out;
        bus_trdy = 1'b0;
      end else if (bus_frame && bus_irdy) begin
        tog = ~tog;
        if (!wait_mode || tog) begin
          if (bus_cbe_n != 4'b0000) be_err++;
          bus_trdy  = 1'b1;
          bus_ad_in = mem(cur_addr);
          bus_par   = (^{mem(cur_addr), bus_cbe_n}) ^ (phase_cnt == bad_idx);
          phase_cnt++;
          cur_addr  = cur_addr + 32'd4;
        end else begin
          bus_trdy = 1'b0;
        end
      end else begin
        bus_trdy = 1'b0;
      end
    end
  endtask

  task automatic run_fetch(input logic [31:0] base, input bit setup,
                           input logic [7:0] mode, input int exp_phases,
                           input int bad, input bit waits);
    tick();
    txn_cnt = 0; phase_cnt = 0; be_err = 0; gap_cnt = 0;
    bad_idx = bad; wait_mode = waits; tog = 1'b0;
    req_valid = 1'b1; req_base = base; req_setup = setup; layout_mode = mode;
    tick();
    req_valid = 1'b0;
    while (phase_cnt < exp_phases) tick();
    tick();
    chk(!bus_frame && bus_irdy, "R6 tail cycle frame/irdy",
        {bus_frame, bus_irdy}, 2'b01);
    tick();
    chk(!bus_frame && !bus_irdy && done && req_ready, "R6 idle cycle frame/irdy/done/ready",
        {bus_frame, bus_irdy, done, req_ready}, 4'b0011);
  endtask

  task automatic t_reset();
    chk(req_ready && !bus_frame && !bus_irdy && !done && !sint_stat && !irq,
        "R6 R7 R9 reset state", {req_ready, bus_frame, bus_irdy, done, sint_stat, irq},
        6'b100000);
  endtask

  task automatic t_setup();
    run_fetch(32'h2000_0013, 1'b1, 8'd3, SETUP_DW, -1, 1'b0);
    chk(txn_cnt == 1, "R1 setup transaction count", txn_cnt, 1);
    chk(txn_cmd[0] == 4'b1100, "R1 setup command", txn_cmd[0], 4'b1100);
    chk(txn_addr[0] == 32'h2000_0010, "R2 setup address low bits", txn_addr[0], 32'h2000_0010);
    chk(phase_cnt == SETUP_DW, "R1 setup beats", phase_cnt, SETUP_DW);
    chk(be_err == 0, "R3 byte enables in setup", be_err, 0);
    chk(rd_count == 3'd7, "R5 setup count", rd_count, 7);
    for (int i = 0; i < SETUP_DW; i++)
      chk(rd_data[32*i +: 32] == mem(32'h2000_0010 + 4*i), "R5 setup dword",
          rd_data[32*i +: 32], mem(32'h2000_0010 + 4*i));
    chk(!sint_stat, "R7 no error on clean setup", sint_stat, 0);
  endtask

  task automatic t_desc(input logic [7:0] mode, input bit waits, input bit single);
    logic [31:0] base;
    base = 32'h0004_1000 + {mode, 4'h0};
    run_fetch(base, 1'b0, mode, DESC_DW, -1, waits);
    if (single) begin
      chk(txn_cnt == DESC_DW, "R4 single-mode transaction count", txn_cnt, DESC_DW);
      chk(gap_cnt == DESC_DW, "R4 idle after each single", gap_cnt, DESC_DW);
      for (int i = 0; i < DESC_DW; i++) begin
        chk(txn_cmd[i] == 4'b0110, "R4 single command", txn_cmd[i], 4'b0110);
        chk(txn_addr[i] == base + 4*i, "R2 single address step", txn_addr[i], base + 4*i);
      end
    end else begin
      chk(txn_cnt == 1, "R4 burst-mode transaction count", txn_cnt, 1);
      chk(txn_cmd[0] == 4'b1100, "R4 burst command", txn_cmd[0], 4'b1100);
    end
    chk(be_err == 0, "R3 byte enables in descriptor", be_err, 0);
    chk(rd_count == 3'(DESC_DW), "R5 descriptor count", rd_count, DESC_DW);
    for (int i = 0; i < DESC_DW; i++)
      chk(rd_data[32*i +: 32] == (mem(base + 4*i) & desc_mask(i)), "R5 descriptor dword kept bytes",
          rd_data[32*i +: 32], mem(base + 4*i) & desc_mask(i));
    for (int i = DESC_DW; i < BUF_DW; i++)
      chk(rd_data[32*i +: 32] == 32'd0, "R5 unused slot zero", rd_data[32*i +: 32], 0);
  endtask

  task automatic t_parity();
    sint_en = 1'b0;
    run_fetch(32'h3000_0000, 1'b1, 8'd0, SETUP_DW, 2, 1'b1);
    chk(sint_stat, "R7 status set by parity error", sint_stat, 1);
    chk(!irq, "R9 masked interrupt", irq, 0);
    chk(txn_cnt == 1 && phase_cnt == SETUP_DW, "R8 traffic unchanged by error",
        {txn_cnt[7:0], phase_cnt[7:0]}, {8'd1, 8'(SETUP_DW)});
    chk(rd_data[64 +: 32] == mem(32'h3000_0008), "R8 errored dword kept",
        rd_data[64 +: 32], mem(32'h3000_0008));
    sint_en = 1'b1;
    #1;
    chk(irq, "R9 interrupt when enabled", irq, 1);
    run_fetch(32'h3000_0100, 1'b0, 8'd5, DESC_DW, -1, 1'b0);
    chk(sint_stat, "R7 status sticky over clean fetch", sint_stat, 1);
    tick();
    sint_clr = 1'b1;
    tick();
    sint_clr = 1'b0;
    chk(!sint_stat && !irq, "R10 clear pulse", {sint_stat, irq}, 2'b00);
    run_fetch(32'h3000_0200, 1'b0, 8'd2, DESC_DW, 1, 1'b0);
    chk(sint_stat && irq, "R7 R9 error in single mode", {sint_stat, irq}, 2'b11);
    chk(txn_cnt == DESC_DW, "R8 single traffic unchanged by error", txn_cnt, DESC_DW);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_base = '0; req_setup = 1'b0; layout_mode = '0;
    bus_trdy = 1'b0; bus_ad_in = '0; bus_par = 1'b0;
    sint_en = 1'b0; sint_clr = 1'b0;
    txn_cnt = 0; phase_cnt = 0; bad_idx = -1; be_err = 0; gap_cnt = 0;
    wait_mode = 1'b0; tog = 1'b0; prev_tail = 1'b0; cur_addr = '0;
    fork
      target_serve();
    join_none
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_setup();
    t_desc(8'd0, 1'b0, 1'b1);
    t_desc(8'd2, 1'b1, 1'b1);
    t_desc(8'd1, 1'b1, 1'b0);
    t_parity();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule